// File: doc/BRIEF.md
# CAN identifier acceptance filter

This block sits behind a CAN receiver and decides, for every completed frame in the background receive buffer, whether the frame goes to the host or is dropped. When it is dropped, the next frame simply overwrites it. The receiver presents the four identifier bytes of the frame, a flag that marks an extended-format frame, and a one-cycle strobe when the frame is complete. The block compares the identifier against two banks of filters. Each bank holds four 8-bit acceptance codes and four 8-bit masks.

The comparison works bit by bit. A mask bit of 1 makes the matching identifier bit a don't-care. A mask bit of 0 requires the identifier bit to equal the code bit. An extended frame is tested on all four bytes. A standard frame is tested on bytes 0 and 1 only. A frame is accepted if either bank matches. When both banks match, bank 0 is reported. An accepted frame produces a one-cycle accept pulse and records the winning bank. It also sets a sticky receive-ready flag, which the host clears by writing 1.

The host reaches the filters through a word-wide register port, and reads of that port have one cycle of latency. Filter writes take effect only while both the initialization-request and initialization-acknowledge inputs are high.

Top module: `can_id_filter`

## Requirements
- R1: After reset, every filter register reads 0x0000, `acc_pulse` is 0, `acc_bank` is 0 and `rx_ready` is 0.
- R2: Within a compared byte, a mask bit of 1 ignores that identifier bit. A mask bit of 0 requires the identifier bit to equal the code bit.
- R3: When `rx_ext` is 1, all four identifier bytes are compared in a bank. Byte n is `rx_id[8n+7:8n]`.
- R4: When `rx_ext` is 0, only bytes 0 and 1 are compared. Bytes 2 and 3 of the identifier, code and mask have no effect.
- R5: A frame that matches no bank produces no `acc_pulse`. It leaves `rx_ready` and `acc_bank` unchanged.
- R6: For a matching frame, `acc_pulse` is 1 in the cycle after `rx_done` is sampled, and lasts one cycle per strobe.
- R7: A frame is accepted when either bank matches. `acc_bank` gives the matching bank, and it is 0 when both banks match.
- R8: A write to a filter register takes effect only while `init_req` and `init_ack` are both 1. At any other time the write is ignored and the register keeps its value.
- R9: Bits 15:8 of every register read as 0, and writes to them are ignored. The code or mask value lives in bits 7:0.
- R10: `reg_rdata` shows the register at `reg_addr` one cycle later. Bank b, byte n sits at word 10h+8b+n for the code and at 14h+8b+n for the mask. The status word at 01h is {`acc_bank` in bit 1, `rx_ready` in bit 0}. Any other address reads 0.
- R11: `rx_ready` is set by every accepted frame and stays set. A write to 01h with bit 0 = 1 clears it at any time, whatever the initialization inputs are. An accept in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after the address |
| init_req | input | 1 | Initialization request state |
| init_ack | input | 1 | Initialization acknowledge state |
| rx_id | input | 32 | Received identifier bytes 0..3, byte 0 in the low bits |
| rx_ext | input | 1 | 1 for an extended-format frame, 0 for a standard-format frame |
| rx_done | input | 1 | Frame-complete strobe |
| acc_pulse | output | 1 | One-cycle accept pulse |
| acc_bank | output | 1 | Bank that matched the last accepted frame |
| rx_ready | output | 1 | Sticky frame-available flag for the host |

## Verification
The filters are set up so that each bank constrains different bits:
- Bank 0 uses nibble-wide masks on bytes 1 and 3.
- Bank 1 checks only byte 0.

Identifiers are then driven in both formats so that each outcome shows up:
- Frames that hit both banks, which show the priority.
- Frames that hit only bank 1 because bank 0 fails in byte 2 or byte 3.
- Frames that hit neither bank.

The same identifier is sent once as extended and once as standard, which separates four-byte from two-byte comparison. Rejections that follow an accept from each bank show that the recorded bank and the ready flag are left alone. Directed steps cover the write gating, the reserved bits, and an accept that collides with a clear.

// File: rtl/canf_pkg.sv
package canf_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned STAT_ADDR = 1;

  typedef enum logic { KIND_CODE = 1'b0, KIND_MASK = 1'b1 } reg_kind_e;

  // flat index of a filter byte: banks in order, codes then masks within a bank
  function automatic int unsigned filt_index(input int unsigned bank,
                                             input reg_kind_e kind,
                                             input int unsigned byte_n,
                                             input int unsigned nbyte);
    return bank * 2 * nbyte + (kind == KIND_MASK ? nbyte : 0) + byte_n;
  endfunction
endpackage

// File: rtl/canf_regfile.sv
module canf_regfile
  import canf_pkg::*;
#(
  parameter int unsigned NBANK = 2,
  parameter int unsigned NBYTE = 4,
  parameter int unsigned IDX_W = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [CODE_W-1:0]               wr_byte,
  input  logic                            init_req,
  input  logic                            init_ack,
  output logic [NBANK*2*NBYTE-1:0][CODE_W-1:0] regs
);
  localparam int unsigned NREG = NBANK * 2 * NBYTE;

  logic wr_ok;
  assign wr_ok = init_req & init_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (wr_en && wr_ok && (32'(wr_idx) < NREG)) begin
      regs[wr_idx] <= wr_byte;
    end
  end

  AST_GATED_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(init_req && init_ack) |=> $stable(regs)); // R8
endmodule

// File: rtl/canf_bank_match.sv
module canf_bank_match
  import canf_pkg::*;
#(
  parameter int unsigned NBYTE     = 4,
  parameter int unsigned STD_BYTES = 2
) (
  input  logic [NBYTE*CODE_W-1:0] id,
  input  logic                    ext,
  input  logic [NBYTE*CODE_W-1:0] code,
  input  logic [NBYTE*CODE_W-1:0] mask,
  output logic                    hit
);
  logic [NBYTE-1:0] byte_ok;
  logic [NBYTE-1:0] byte_used;

  for (genvar n = 0; n < NBYTE; n++) begin : g_byte
    logic [CODE_W-1:0] id_b, code_b, mask_b;
    assign id_b   = id[n*CODE_W +: CODE_W];
    assign code_b = code[n*CODE_W +: CODE_W];
    assign mask_b = mask[n*CODE_W +: CODE_W];
    // every bit either equal or masked out
    assign byte_ok[n] = &(~(id_b ^ code_b) | mask_b);
    if (n < STD_BYTES) begin : g_std
      assign byte_used[n] = 1'b1;
    end else begin : g_ext
      assign byte_used[n] = ext;
    end
  end

  assign hit = &(byte_ok | ~byte_used);
endmodule

// File: rtl/canf_decide.sv
module canf_decide #(
  parameter int unsigned NBANK  = 2,
  parameter int unsigned BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_done,
  input  logic [NBANK-1:0]  hit,
  input  logic              clr,
  output logic              acc_pulse,
  output logic [BANK_W-1:0] acc_bank,
  output logic              rx_ready
);
  logic [BANK_W-1:0] win;
  logic              take;

  always_comb begin
    win = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (hit[b]) win = BANK_W'(b);
    end
  end

  assign take = rx_done & (|hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_pulse <= 1'b0;
      acc_bank  <= '0;
      rx_ready  <= 1'b0;
    end else begin
      acc_pulse <= take;
      if (take) acc_bank <= win;
      if (take)      rx_ready <= 1'b1;
      else if (clr)  rx_ready <= 1'b0;
    end
  end

  AST_PULSE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |-> $past(rx_done)); // R6
  AST_READY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |-> rx_ready); // R11
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !clr) |=> rx_ready); // R11
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import canf_pkg::*;
#(
  parameter int unsigned NBANK     = 2,
  parameter int unsigned NBYTE     = 4,
  parameter int unsigned STD_BYTES = 2,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FILT_BASE = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic                    init_req,
  input  logic                    init_ack,
  input  logic [NBYTE*CODE_W-1:0] rx_id,
  input  logic                    rx_ext,
  input  logic                    rx_done,
  output logic                    acc_pulse,
  output logic [(NBANK>1?$clog2(NBANK):1)-1:0] acc_bank,
  output logic                    rx_ready
);
  localparam int unsigned NREG   = NBANK * 2 * NBYTE;
  localparam int unsigned IDX_W  = $clog2(NREG);
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(FILT_BASE);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  // filter window must be aligned to its size so the low address bits index it
  logic             filt_sel;
  logic [IDX_W-1:0] idx;
  assign filt_sel = (reg_addr[ADDR_W-1:IDX_W] == BASE_A[ADDR_W-1:IDX_W]);
  assign idx      = reg_addr[IDX_W-1:0];

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[DATA_W-1:CODE_W];

  logic [NREG-1:0][CODE_W-1:0] regs;

  canf_regfile #(.NBANK(NBANK), .NBYTE(NBYTE), .IDX_W(IDX_W)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr & filt_sel),
    .wr_idx  (idx),
    .wr_byte (reg_wdata[CODE_W-1:0]),
    .init_req(init_req),
    .init_ack(init_ack),
    .regs    (regs)
  );

  logic [NBANK-1:0] hit;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NBYTE*CODE_W-1:0] code_v, mask_v;
    for (genvar n = 0; n < NBYTE; n++) begin : g_b
      assign code_v[n*CODE_W +: CODE_W] = regs[filt_index(b, KIND_CODE, n, NBYTE)];
      assign mask_v[n*CODE_W +: CODE_W] = regs[filt_index(b, KIND_MASK, n, NBYTE)];
    end
    canf_bank_match #(.NBYTE(NBYTE), .STD_BYTES(STD_BYTES)) match_i (
      .id  (rx_id),
      .ext (rx_ext),
      .code(code_v),
      .mask(mask_v),
      .hit (hit[b])
    );
  end

  logic clr;
  assign clr = reg_wr && (reg_addr == STAT_A) && reg_wdata[0];

  canf_decide #(.NBANK(NBANK), .BANK_W(BANK_W)) decide_i (
    .clk      (clk),
    .rst      (rst),
    .rx_done  (rx_done),
    .hit      (hit),
    .clr      (clr),
    .acc_pulse(acc_pulse),
    .acc_bank (acc_bank),
    .rx_ready (rx_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_addr == STAT_A) begin
      reg_rdata <= DATA_W'({acc_bank, rx_ready});
    end else if (filt_sel) begin
      reg_rdata <= DATA_W'(regs[idx]);
    end else begin
      reg_rdata <= '0;
    end
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:CODE_W] == '0); // R9
  AST_NO_HIT_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !(|hit)) |=> !acc_pulse); // R5
  AST_BANK0_PRIO: assert property (@(posedge clk) disable iff (rst)
    (rx_done && hit[0]) |=> (acc_pulse && acc_bank == '0)); // R7
  AST_HIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rx_done && (|hit)) |=> acc_pulse); // R6
endmodule

// File: tb/can_id_filter_tb_top.sv
module can_id_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        init_req = 1'b0, init_ack = 1'b0;
  logic [31:0] rx_id = '0;
  logic        rx_ext = 1'b0, rx_done = 1'b0;
  logic        acc_pulse;
  logic [0:0]  acc_bank;
  logic        rx_ready;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  can_id_filter dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .init_req(init_req),
    .init_ack(init_ack), .rx_id(rx_id), .rx_ext(rx_ext), .rx_done(rx_done),
    .acc_pulse(acc_pulse), .acc_bank(acc_bank), .rx_ready(rx_ready)
  );

  // {ext, id, expected accept, expected bank}
  localparam logic [34:0] VEC [10] = '{
    {1'b1, 32'h7856_3412, 1'b1, 1'b0},
    {1'b1, 32'h0056_3F12, 1'b1, 1'b1},
    {1'b1, 32'h0057_3412, 1'b1, 1'b1},
    {1'b1, 32'h7856_3413, 1'b0, 1'b0},
    {1'b0, 32'hFFFF_3412, 1'b1, 1'b0},
    {1'b0, 32'h0000_4412, 1'b1, 1'b1},
    {1'b0, 32'h0056_3492, 1'b0, 1'b0},
    {1'b1, 32'hA856_3512, 1'b1, 1'b0},
    {1'b0, 32'h0057_3412, 1'b1, 1'b0},
    {1'b0, 32'h0000_1234, 1'b0, 1'b0}
  };

  // bank 0: code 12 34 56 78, mask 00 0F 00 F0; bank 1: code 12 30 00 00, mask 00 FF FF FF
  localparam logic [7:0] CFG [16] = '{
    8'h12, 8'h34, 8'h56, 8'h78, 8'h00, 8'h0F, 8'h00, 8'hF0,
    8'h12, 8'h30, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic        last_bank;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 acc_pulse after reset", 32'(acc_pulse), 0);
    chk("R1 rx_ready after reset", 32'(rx_ready), 0);
    rd(6'h10, d); chk("R1 code reg after reset", 32'(d), 0);
    rd(6'h1F, d); chk("R1 mask reg after reset", 32'(d), 0);

    // R8: request without acknowledge does not open the registers
    init_req = 1'b1;
    wr(6'h10, 16'h0055);
    rd(6'h10, d); chk("R8 write with ack low", 32'(d), 0);

    // R9: reserved high byte
    init_ack = 1'b1;
    wr(6'h10, 16'hFFFF);
    rd(6'h10, d); chk("R9 reserved bits", 32'(d), 32'h00FF);

    for (int i = 0; i < 16; i++) wr(6'(16 + i), {8'hA5, CFG[i]});
    rd(6'h19, d); chk("R10 bank1 code byte1", 32'(d), 32'h0030);
    rd(6'h15, d); chk("R10 bank0 mask byte1", 32'(d), 32'h000F);
    rd(6'h02, d); chk("R10 unmapped address", 32'(d), 0);

    init_req = 1'b0;
    wr(6'h10, 16'h0000);
    rd(6'h10, d); chk("R8 write outside init", 32'(d), 32'h0012);
    init_ack = 1'b0;

    last_bank = 1'b0;
    for (int v = 0; v < 10; v++) begin
      rx_ext = VEC[v][34]; rx_id = VEC[v][33:2]; rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0;
      chk($sformatf("R2 R3 R4 R6 accept vec%0d", v), 32'(acc_pulse), 32'(VEC[v][1]));
      if (VEC[v][1]) begin
        chk($sformatf("R7 bank vec%0d", v), 32'(acc_bank), 32'(VEC[v][0]));
        last_bank = VEC[v][0];
        @(negedge clk);
        chk($sformatf("R6 single pulse vec%0d", v), 32'(acc_pulse), 0);
        rd(6'h01, d); chk($sformatf("R10 R11 status vec%0d", v), 32'(d), {30'd0, last_bank, 1'b1});
        wr(6'h01, 16'h0001);
        chk($sformatf("R11 clear vec%0d", v), 32'(rx_ready), 0);
      end else begin
        chk($sformatf("R5 ready kept vec%0d", v), 32'(rx_ready), 0);
        chk($sformatf("R5 bank kept vec%0d", v), 32'(acc_bank), 32'(last_bank));
      end
    end

    // R11: sticky, then accept wins over a simultaneous clear
    rx_ext = 1'b1; rx_id = 32'h0057_3412; rx_done = 1'b1;
    @(negedge clk);
    rx_done = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 ready sticky", 32'(rx_ready), 1);
    rx_done = 1'b1;
    wr(6'h01, 16'h0001);
    rx_done = 1'b0;
    chk("R11 set beats clear", 32'(rx_ready), 1);
    chk("R7 bank1 only", 32'(acc_bank), 1);
    wr(6'h01, 16'h0000);
    chk("R11 write 0 keeps ready", 32'(rx_ready), 1);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ready after second reset", 32'(rx_ready), 0);
    chk("R1 bank after second reset", 32'(acc_bank), 0);
    rd(6'h18, d); chk("R1 regs after second reset", 32'(d), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule